// File: doc/BRIEF.md
# Cartridge Bus Timing Sequencer

This block moves 16-bit words over a parallel cartridge bus on behalf of a DMA engine, and it runs on the core clock. A transfer starts with a command that gives a byte address, a length in words and a direction. The block latches the address onto a shared address/data bus in two halves. For each word it then waits out a latency phase, pulses the read or write strobe, and holds the strobe inactive for a release phase. Each of these phase lengths comes from a small programmable timing field.

A page size field divides the address space into pages. When the running address reaches the start of a new page and words remain, the block latches the new address before it continues. When the release phase of the last word ends, the block returns to idle and pulses done. Software programs the four timing fields through a register port. Writes to that port are locked out while a transfer is running.

Top module: `cart_bus_seq`

## Requirements
- R1: After reset the block is idle. Busy, done, both latch outputs and the bus output enable are low, and both strobes are high. The timing fields read back latency 3, pulse width 4, page size 7 and release 3.
- R2: The register map places latency in bits [7:0] at offset 0x24, pulse width in bits [7:0] at 0x28, page size in bits [3:0] at 0x2C and release in bits [1:0] at 0x30. Bits outside a field read as zero, and any other offset reads as zero.
- R3: A register write made while busy is high leaves every field unchanged.
- R4: A transfer begins with one cycle of the high latch carrying address bits [31:16] and then one cycle of the low latch carrying bits [15:0]. The output enable is high and both strobes are high during both cycles. Address bit 0 is ignored, so the address is taken as even.
- R5: After the low latch cycle, the strobes stay high for latency + 1 cycles before the first strobe.
- R6: Each word asserts exactly one strobe low for pulse width + 1 cycles. Reads use the read strobe with the output enable low, and the input word sampled on the last strobe cycle appears on rd_data with a one-cycle word_ack. Writes use the write strobe with wr_data driven and the output enable high, and word_ack pulses after the strobe.
- R7: After every strobe, both strobes stay high for release + 1 cycles. If words remain and no page boundary was reached, a latency phase of latency + 1 cycles follows and then the next strobe.
- R8: The page is 2^(page size + 2) bytes long. The address advances by 2 after every word. If words remain and the advanced address is page-aligned, the release phase is followed by a fresh high/low latch pair carrying the advanced address, and then a latency phase.
- R9: Busy goes high in the cycle after an accepted start and stays high until the transfer ends. Done is high for exactly one cycle, and that cycle is the first one with busy low, immediately after the last release phase.
- R10: A start with length zero raises done in the next cycle with no latch or strobe activity, and busy stays low.
- R11: A start command seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| cmd_start | input | 1 | Start a transfer (accepted when idle) |
| cmd_write | input | 1 | 1 = write to cartridge, 0 = read |
| cmd_addr | input | 32 | Starting byte address |
| cmd_len | input | 16 | Number of 16-bit words |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_data | input | 16 | Word to write, held by the source until word_ack |
| rd_data | output | 16 | Last word read from the cartridge |
| word_ack | output | 1 | One-cycle pulse after each word's strobe |
| bus_ad_out | output | 16 | Address/data bus output value |
| bus_ad_oe | output | 1 | Address/data bus output enable |
| bus_ad_in | input | 16 | Address/data bus input value |
| bus_ale_hi | output | 1 | High address half latch |
| bus_ale_lo | output | 1 | Low address half latch |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The assertions check the rules that hold in every cycle. The two strobes are never low together, and the bus direction matches the active strobe. The latch cycles come in high-then-low pairs with both strobes inactive. Every strobe pulse lasts exactly pulse width + 1 cycles. Done is a single-cycle pulse that coincides with busy falling, the bus is quiet whenever the block is idle, and register contents stay frozen while busy. Other properties depend on the programmed fields and on the address sequence: the latency and release gaps between events, re-latching at page boundaries, the data values carried, and a stray start being ignored. Only the scoreboard scenarios show those, by comparing each observed bus event with one predicted from the command.

// File: rtl/cbs_pkg.sv
// Package: shared state encoding and register offsets for the cartridge
// bus timing sequencer. Offsets are byte offsets within the block window.
package cbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_LATENCY,
        ST_STROBE,
        ST_RELEASE
    } cbs_state_e;

    localparam int OFS_LATENCY = 'h24;
    localparam int OFS_PULSE   = 'h28;
    localparam int OFS_PAGE    = 'h2C;
    localparam int OFS_RELEASE = 'h30;

    // Page length in bytes is 2^(page field + PAGE_BIAS).
    localparam int PAGE_BIAS   = 2;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cbs_regs.sv
// Module: cbs_regs
// Holds the four timing fields and serves combinational reads.
// Assumes: each field fits in REG_DW bits; writes are dropped while lock is high.
module cbs_regs
    import cbs_pkg::*;
#(
    parameter int LAT_W   = 8,
    parameter int PWD_W   = 8,
    parameter int PGS_W   = 4,
    parameter int RLS_W   = 2,
    parameter int REG_AW  = 6,
    parameter int REG_DW  = 32,
    parameter int LAT_RST = 3,
    parameter int PWD_RST = 4,
    parameter int PGS_RST = 7,
    parameter int RLS_RST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              lock,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic [REG_DW-1:0] rdata,
    output logic [LAT_W-1:0]  lat_o,
    output logic [PWD_W-1:0]  pwd_o,
    output logic [PGS_W-1:0]  pgs_o,
    output logic [RLS_W-1:0]  rls_o
);

    logic sel_lat, sel_pwd, sel_pgs, sel_rls;
    logic wr_ok;
    logic unused_wdata;

    // Decode the offset into one select per field.
    always_comb begin
        sel_lat = (addr == REG_AW'(OFS_LATENCY));
        sel_pwd = (addr == REG_AW'(OFS_PULSE));
        sel_pgs = (addr == REG_AW'(OFS_PAGE));
        sel_rls = (addr == REG_AW'(OFS_RELEASE));
        wr_ok   = wr_en && !lock;
    end

    assign unused_wdata = ^wdata;

    // Field storage with reset defaults; writes gated by the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_o <= LAT_W'(LAT_RST);
            pwd_o <= PWD_W'(PWD_RST);
            pgs_o <= PGS_W'(PGS_RST);
            rls_o <= RLS_W'(RLS_RST);
        end else if (wr_ok) begin
            if (sel_lat) lat_o <= wdata[LAT_W-1:0];
            if (sel_pwd) pwd_o <= wdata[PWD_W-1:0];
            if (sel_pgs) pgs_o <= wdata[PGS_W-1:0];
            if (sel_rls) rls_o <= wdata[RLS_W-1:0];
        end
    end

    // Read mux: zero-extended field, zero for unmapped offsets.
    always_comb begin
        rdata = '0;
        if (sel_lat) rdata = REG_DW'(lat_o);
        if (sel_pwd) rdata = REG_DW'(pwd_o);
        if (sel_pgs) rdata = REG_DW'(pgs_o);
        if (sel_rls) rdata = REG_DW'(rls_o);
    end

endmodule

// File: rtl/cbs_phase_cnt.sv
// Module: cbs_phase_cnt
// A single up-counter shared by all timed phases. It counts from zero and
// flags the cycle in which the count equals the phase limit.
// Assumes: the sequencer clears it on entry to each timed phase.
module cbs_phase_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Count up each cycle, back to zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Terminal-count compare.
    assign last = (cnt_q == limit);

endmodule

// File: rtl/cbs_addr_gen.sv
// Module: cbs_addr_gen
// Running byte address: loaded at start, advanced one word per strobe, and
// flags when it sits on a page boundary for the programmed page size.
// Assumes: STEP is a power of two; the low alignment bits of the start are dropped.
module cbs_addr_gen
    import cbs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PGS_W  = 4,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [PGS_W-1:0]  pgs,
    output logic [ADDR_W-1:0] addr,
    output logic              at_boundary
);

    localparam int ALIGN_W = (STEP > 1) ? $clog2(STEP) : 0;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(STEP - 1);

    logic [ADDR_W-1:0] page_mask;
    int                page_shift;

    // Address register: load aligned start, then step per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= start_addr & ~ALIGN_MASK;
        end else if (step) begin
            addr <= addr + ADDR_W'(STEP);
        end
    end

    // Build the in-page offset mask and test it against the address.
    always_comb begin
        page_shift = int'(pgs) + PAGE_BIAS;
        for (int i = 0; i < ADDR_W; i++) begin
            page_mask[i] = (i < page_shift);
        end
        at_boundary = ((addr & page_mask) == '0);
    end

endmodule

// File: rtl/cbs_fsm.sv
// Module: cbs_fsm
// Phase sequencer: address high, address low, latency, strobe, release,
// then latency again, a fresh address at a page boundary, or idle.
// Assumes: the phase counter restarts from zero whenever cnt_clr is high.
module cbs_fsm
    import cbs_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int LAT_W = 8,
    parameter int PWD_W = 8,
    parameter int RLS_W = 2,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic [LEN_W-1:0] len,
    input  logic [LAT_W-1:0] lat,
    input  logic [PWD_W-1:0] pwd,
    input  logic [RLS_W-1:0] rls,
    input  logic             cnt_last,
    input  logic             at_boundary,
    output cbs_state_e       state,
    output logic             cnt_clr,
    output logic [CNT_W-1:0] cnt_limit,
    output logic             addr_load,
    output logic             word_end,
    output logic             wr_mode,
    output logic             busy,
    output logic             done
);

    logic [LEN_W-1:0] words_left;
    logic             timed;

    // Phase transitions, word bookkeeping and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            words_left <= '0;
            wr_mode    <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (len == '0) begin
                            done <= 1'b1;
                        end else begin
                            state      <= ST_ADDR_HI;
                            words_left <= len;
                            wr_mode    <= is_write;
                        end
                    end
                end
                ST_ADDR_HI: state <= ST_ADDR_LO;
                ST_ADDR_LO: state <= ST_LATENCY;
                ST_LATENCY: begin
                    if (cnt_last) state <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (cnt_last) begin
                        state      <= ST_RELEASE;
                        words_left <= words_left - LEN_W'(1);
                    end
                end
                ST_RELEASE: begin
                    if (cnt_last) begin
                        if (words_left == '0) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else if (at_boundary) begin
                            state <= ST_ADDR_HI;
                        end else begin
                            state <= ST_LATENCY;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Select the limit of the current timed phase and control the counter.
    always_comb begin
        timed = (state == ST_LATENCY) || (state == ST_STROBE) || (state == ST_RELEASE);
        case (state)
            ST_LATENCY: cnt_limit = CNT_W'(lat);
            ST_STROBE:  cnt_limit = CNT_W'(pwd);
            ST_RELEASE: cnt_limit = CNT_W'(rls);
            default:    cnt_limit = '0;
        endcase
        cnt_clr   = !timed || cnt_last;
        addr_load = (state == ST_IDLE) && start && (len != '0);
        word_end  = (state == ST_STROBE) && cnt_last;
        busy      = (state != ST_IDLE);
    end

endmodule

// File: rtl/cart_bus_seq.sv
// Module: cart_bus_seq (top)
// Sequences cartridge bus transfers: two address latch cycles, then per word
// a latency wait, a strobe pulse and a release wait, re-latching the address
// at page boundaries. Bus pins are decoded from the phase state.
// Assumes: ADDR_W is twice BUS_W; wr_data is held by its source until word_ack.
module cart_bus_seq
    import cbs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 16,
    parameter int LEN_W  = 16,
    parameter int LAT_W  = 8,
    parameter int PWD_W  = 8,
    parameter int PGS_W  = 4,
    parameter int RLS_W  = 2,
    parameter int REG_AW = 6,
    parameter int REG_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              cmd_start,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              busy,
    output logic              done,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    output logic              word_ack,
    output logic [BUS_W-1:0]  bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [BUS_W-1:0]  bus_ad_in,
    output logic              bus_ale_hi,
    output logic              bus_ale_lo,
    output logic              bus_rd_n,
    output logic              bus_wr_n
);

    localparam int CNT_W     = max3(LAT_W, PWD_W, RLS_W);
    localparam int WORD_STEP = BUS_W / 8;

    logic [LAT_W-1:0]  lat_q;
    logic [PWD_W-1:0]  pwd_q;
    logic [PGS_W-1:0]  pgs_q;
    logic [RLS_W-1:0]  rls_q;
    cbs_state_e        state;
    logic              cnt_clr;
    logic [CNT_W-1:0]  cnt_limit;
    logic              cnt_last;
    logic              addr_load;
    logic              word_end;
    logic              wr_mode;
    logic              at_boundary;
    logic [ADDR_W-1:0] cur_addr;
    logic              in_strobe;

    cbs_regs #(
        .LAT_W (LAT_W),
        .PWD_W (PWD_W),
        .PGS_W (PGS_W),
        .RLS_W (RLS_W),
        .REG_AW(REG_AW),
        .REG_DW(REG_DW)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(reg_wr_en),
        .lock (busy),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .rdata(reg_rdata),
        .lat_o(lat_q),
        .pwd_o(pwd_q),
        .pgs_o(pgs_q),
        .rls_o(rls_q)
    );

    cbs_phase_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .limit(cnt_limit),
        .last (cnt_last)
    );

    cbs_addr_gen #(
        .ADDR_W(ADDR_W),
        .PGS_W (PGS_W),
        .STEP  (WORD_STEP)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (addr_load),
        .step       (word_end),
        .start_addr (cmd_addr),
        .pgs        (pgs_q),
        .addr       (cur_addr),
        .at_boundary(at_boundary)
    );

    cbs_fsm #(
        .LEN_W(LEN_W),
        .LAT_W(LAT_W),
        .PWD_W(PWD_W),
        .RLS_W(RLS_W),
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cmd_start),
        .is_write   (cmd_write),
        .len        (cmd_len),
        .lat        (lat_q),
        .pwd        (pwd_q),
        .rls        (rls_q),
        .cnt_last   (cnt_last),
        .at_boundary(at_boundary),
        .state      (state),
        .cnt_clr    (cnt_clr),
        .cnt_limit  (cnt_limit),
        .addr_load  (addr_load),
        .word_end   (word_end),
        .wr_mode    (wr_mode),
        .busy       (busy),
        .done       (done)
    );

    // Decode bus pins from the phase state.
    always_comb begin
        in_strobe  = (state == ST_STROBE);
        bus_ale_hi = (state == ST_ADDR_HI);
        bus_ale_lo = (state == ST_ADDR_LO);
        bus_rd_n   = !(in_strobe && !wr_mode);
        bus_wr_n   = !(in_strobe && wr_mode);
        bus_ad_oe  = bus_ale_hi || bus_ale_lo || (in_strobe && wr_mode);
        if (bus_ale_hi) begin
            bus_ad_out = cur_addr[ADDR_W-1 -: BUS_W];
        end else if (bus_ale_lo) begin
            bus_ad_out = cur_addr[BUS_W-1:0];
        end else if (in_strobe && wr_mode) begin
            bus_ad_out = wr_data;
        end else begin
            bus_ad_out = '0;
        end
    end

    // Capture read data at the end of a read strobe and acknowledge each word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            word_ack <= 1'b0;
        end else begin
            word_ack <= word_end;
            if (word_end && !wr_mode) begin
                rd_data <= bus_ad_in;
            end
        end
    end

endmodule

// File: rtl/cbs_checker.sv
// Module: cbs_checker
// Protocol properties for cart_bus_seq, attached by bind below.
// Assumes: pwd is the live pulse-width field, stable while busy.
module cbs_checker #(
    parameter int PWD_W  = 8,
    parameter int REG_AW = 6,
    parameter int REG_DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              bus_ad_oe,
    input logic              bus_ale_hi,
    input logic              bus_ale_lo,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_rdata,
    input logic [PWD_W-1:0]  pwd
);

    localparam int RUN_W = PWD_W + 2;

    logic [RUN_W-1:0] low_run;

    // Length of the current strobe-low run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!bus_rd_n || !bus_wr_n) begin
            low_run <= low_run + RUN_W'(1);
        end else begin
            low_run <= '0;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n)); // R6
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_ad_oe); // R6
    AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_ad_oe); // R6
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_n && bus_wr_n && (low_run != '0)) |-> (low_run == RUN_W'(pwd) + RUN_W'(1))); // R6
    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale_hi || bus_ale_lo) |-> (bus_rd_n && bus_wr_n && bus_ad_oe)); // R4
    AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale_hi |=> (bus_ale_lo && !bus_ale_hi)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_rd_n && bus_wr_n && !bus_ale_hi && !bus_ale_lo && !bus_ad_oe)); // R10
    AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(reg_addr)) |-> $stable(reg_rdata)); // R3

endmodule

bind cart_bus_seq cbs_checker #(
    .PWD_W (PWD_W),
    .REG_AW(REG_AW),
    .REG_DW(REG_DW)
) u_cbs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .bus_ad_oe (bus_ad_oe),
    .bus_ale_hi(bus_ale_hi),
    .bus_ale_lo(bus_ale_lo),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .pwd       (pwd_q)
);

// File: tb/test_cart_bus_seq.sv
// Scoreboard bench: driver tasks predict the bus events of each command,
// and a monitor rebuilds events from the pins and compares them in order.
module test_cart_bus_seq;

    localparam int K_AH = 1, K_AL = 2, K_RD = 3, K_WR = 4, K_DONE = 5;

    typedef struct {
        int    kind;
        int    value;
        int    len;
        int    gap;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_start = 1'b0;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic        busy, done;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        word_ack;
    logic [15:0] bus_ad_out;
    logic        bus_ad_oe;
    logic [15:0] bus_ad_in;
    logic        bus_ale_hi, bus_ale_lo, bus_rd_n, bus_wr_n;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    int    sh_lat = 3, sh_pwd = 4, sh_pgs = 7, sh_rls = 3;

    int    gap = 0, run = 0, st_gap = 0, st_kind = 0, st_val = 0;
    int    rd_idx = 0, wr_idx = 0;

    always #4 clk = !clk;

    assign wr_data   = 16'h5000 + 16'(wr_idx);
    assign bus_ad_in = 16'hC000 + 16'(rd_idx);

    cart_bus_seq i_cart_bus_seq (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .busy(busy), .done(done),
        .wr_data(wr_data), .rd_data(rd_data), .word_ack(word_ack),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_ale_hi(bus_ale_hi), .bus_ale_lo(bus_ale_lo), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string kind_req(input int k);
        case (k)
            K_AH, K_AL: return "R4";
            K_RD, K_WR: return "R6";
            default:    return "R9";
        endcase
    endfunction

    task automatic push(input int k, input int v, input int l, input int g, input string t);
        item_t it;
        it.kind = k; it.value = v; it.len = l; it.gap = g; it.tag = t;
        exp_q.push_back(it);
    endtask

    // Compare one observed event with the oldest prediction.
    task automatic emit(input int k, input int v, input int l, input int g);
        item_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R11", "unexpected bus event kind", k, 0);
        end else begin
            e = exp_q.pop_front();
            check(k == e.kind, kind_req(e.kind), "event kind", k, e.kind);
            check(v == e.value, kind_req(e.kind), "event value", v, e.value);
            check(l == e.len, "R6", "event length", l, e.len);
            check(g == e.gap, e.tag, "idle gap before event", g, e.gap);
        end
    endtask

    // Monitor: rebuild latch, strobe and done events at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_ale_hi) begin
                emit(K_AH, int'(bus_ad_out), 1, gap); gap = 0;
            end else if (bus_ale_lo) begin
                emit(K_AL, int'(bus_ad_out), 1, gap); gap = 0;
            end else if (!bus_rd_n || !bus_wr_n) begin
                if (run == 0) begin
                    st_gap = gap; gap = 0;
                    st_kind = !bus_wr_n ? K_WR : K_RD;
                    st_val = int'(bus_ad_out);
                end
                run++;
            end else begin
                if (run != 0) begin
                    emit(st_kind, (st_kind == K_WR) ? st_val : int'(rd_data), run, st_gap);
                    if (st_kind == K_RD) rd_idx++;
                    run = 0;
                end
                if (done) begin
                    emit(K_DONE, 0, 0, gap); gap = 0;
                end else if (busy) begin
                    gap++;
                end else begin
                    gap = 0; rd_idx = 0; wr_idx = 0;
                end
            end
            if (word_ack && busy && !bus_rd_n == 1'b0 && st_kind == K_WR) wr_idx++;
        end
    end

    task automatic reg_write(input int ofs, input logic [31:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 6'(ofs); reg_wdata = val;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_expect(input int ofs, input int exp, input string req);
        @(negedge clk);
        reg_addr = 6'(ofs);
        #1;
        check(reg_rdata == 32'(exp), req, "register read", reg_rdata, exp);
    endtask

    task automatic set_timing(input int lat, input int pwd, input int pgs, input int rls);
        reg_write('h24, 32'(lat)); reg_write('h28, 32'(pwd));
        reg_write('h2C, 32'(pgs)); reg_write('h30, 32'(rls));
        sh_lat = lat; sh_pwd = pwd; sh_pgs = pgs; sh_rls = rls;
    endtask

    // Driver: predict every bus event of the command, then issue it.
    task automatic start_xfer(input bit wr, input logic [31:0] addr, input int len);
        logic [31:0] a, mask;
        bit          reissued;
        mask = (32'd1 << (sh_pgs + 2)) - 32'd1;
        a = addr & ~32'd1;
        reissued = 1'b0;
        if (len == 0) begin
            push(K_DONE, 0, 0, 0, "R10");
        end else begin
            push(K_AH, int'(a[31:16]), 1, 0, "R4");
            push(K_AL, int'(a[15:0]), 1, 0, "R4");
            for (int i = 0; i < len; i++) begin
                push(wr ? K_WR : K_RD, wr ? ('h5000 + i) : ('hC000 + i), sh_pwd + 1,
                     (i == 0 || reissued) ? sh_lat + 1 : sh_rls + sh_lat + 2,
                     (i == 0) ? "R5" : (reissued ? "R8" : "R7"));
                a = a + 32'd2;
                reissued = 1'b0;
                if (i < len - 1 && (a & mask) == 32'd0) begin
                    push(K_AH, int'(a[31:16]), 1, sh_rls + 1, "R8");
                    push(K_AL, int'(a[15:0]), 1, 0, "R8");
                    reissued = 1'b1;
                end
            end
            push(K_DONE, 0, 0, sh_rls + 1, "R9");
        end
        @(negedge clk);
        cmd_start = 1'b1; cmd_write = wr; cmd_addr = addr; cmd_len = 16'(len);
        @(negedge clk);
        cmd_start = 1'b0;
        if (len == 0) begin
            check(busy == 1'b0, "R10", "busy after zero-length start", busy, 0);
            check(done == 1'b1, "R10", "done after zero-length start", done, 1);
        end else begin
            check(busy == 1'b1, "R9", "busy after start", busy, 1);
        end
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
        check(busy == 1'b0, "R9", "busy low with done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R9", "done lasts one cycle", done, 0);
        check(exp_q.size() == 0, "R11", "predicted events left over", exp_q.size(), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the pins and the register defaults
        check(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
        check(bus_rd_n && bus_wr_n, "R1", "strobes after reset", {bus_rd_n, bus_wr_n}, 3);
        check(!bus_ale_hi && !bus_ale_lo && !bus_ad_oe, "R1", "latch/oe after reset",
              {bus_ale_hi, bus_ale_lo, bus_ad_oe}, 0);
        reg_expect('h24, 3, "R1");
        reg_expect('h28, 4, "R1");
        reg_expect('h2C, 7, "R1");
        reg_expect('h30, 3, "R1");

        // R2: field placement, masking and unmapped offsets
        reg_write('h24, 32'h0000_0012); reg_expect('h24, 'h12, "R2");
        reg_write('h28, 32'hFFFF_FFFF); reg_expect('h28, 'hFF, "R2");
        reg_write('h2C, 32'h0000_00AB); reg_expect('h2C, 'hB, "R2");
        reg_write('h30, 32'h0000_00FE); reg_expect('h30, 'h2, "R2");
        reg_expect('h00, 0, "R2");
        reg_expect('h34, 0, "R2");

        // R4 R5 R6 R7 R8: read crossing a 512-byte page
        set_timing(2, 1, 7, 3);
        start_xfer(1'b0, 32'h0001_01FA, 5);
        wait_done();

        // R4 R6 R8: write, shortest phases, 4-byte pages, odd start address
        set_timing(0, 0, 0, 0);
        start_xfer(1'b1, 32'h00AB_CDE1, 5);
        wait_done();

        // R3 R11: register write and stray start while busy
        set_timing(1, 2, 7, 1);
        start_xfer(1'b0, 32'h0000_0010, 3);
        reg_write('h24, 32'h0000_0055);
        @(negedge clk);
        cmd_start = 1'b1; cmd_write = 1'b1; cmd_addr = 32'h1234_0000; cmd_len = 16'd7;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_done();
        reg_expect('h24, 1, "R3");

        // R10: zero-length command
        start_xfer(1'b1, 32'h0000_0100, 0);
        wait_done();

        // R6 R7: longer pulses and release, write without page crossing
        set_timing(3, 5, 7, 2);
        start_xfer(1'b1, 32'h0000_0040, 3);
        wait_done();

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule